// File: doc/BRIEF.md
# Translation Context Qualifier and Fault Reporter

This block sits in front of a radix page-table walker. Each cycle it looks at the two most significant bits of the effective address (the quadrant) and the hypervisor mode bit, and decides which partition identifier and process identifier the walk should use. The values come from the partition and process identifier registers held outside the block, or are forced to zero. In guest mode two of the four quadrants are not legal, and for those the block reports that no context exists.

The block also builds the interrupt syndrome when translation cannot go ahead. A request strobe in an illegal quadrant raises a segment interrupt. A request with the reserved access-type encoding raises a configuration-error storage interrupt. A storage-fault strobe from the walker, which carries a cause word, raises an instruction or data storage interrupt. The error code, the syndrome and the fault address are registered and held until the next interrupt. The interrupt-valid output is a one-cycle pulse issued together with those updates.

Top module: `xlat_ctx_fault`

## Requirements
- R1: With `hv_mode` high, quadrant 0 gives partition 0 and `pid_reg`, quadrant 1 gives `lpid_reg` and `pid_reg`, quadrant 2 gives `lpid_reg` and process 0, and quadrant 3 gives partition 0 and process 0. In every one of these cases `ctx_ok` is 1. The quadrant is `ea[EA_W-1:EA_W-2]`.
- R2: With `hv_mode` low, quadrant 0 gives `lpid_reg` and `pid_reg`, quadrant 3 gives `lpid_reg` and process 0, and `ctx_ok` is 1.
- R3: With `hv_mode` low, quadrants 1 and 2 give `ctx_ok` 0, with both identifier outputs at 0.
- R4: A strobe (`req_stb` or `sfault_stb`) seen while `ctx_ok` is 0 gives a segment interrupt on the next cycle, with `irq_err` cleared and `fault_syn` unchanged. On execute (`acc_type` 2) it is an instruction segment interrupt (`irq_kind` 1) and `fault_dar` does not change. On any other access type it is a data segment interrupt (`irq_kind` 0) and `fault_dar` is loaded with `ea`.
- R5: `sfault_stb` on an execute access in a legal quadrant gives an instruction storage interrupt (`irq_kind` 3). `irq_err` takes `fault_cause`, and `fault_syn` and `fault_dar` do not change.
- R6: `sfault_stb` on a read (`acc_type` 0) or a write (`acc_type` 1) in a legal quadrant gives a data storage interrupt (`irq_kind` 2). `fault_syn` takes `fault_cause`, with bit `STORE_BIT` (default 25) also set on a write. `fault_dar` takes `ea` and `irq_err` is cleared.
- R7: A strobe with `acc_type` 3 in a legal quadrant gives a data storage interrupt. `fault_syn` is set to only bit `CFG_BIT` (default 9), `fault_dar` takes `ea`, and `irq_err` is cleared.
- R8: When causes coincide, the priority is segment, then configuration error, then storage fault.
- R9: `irq_vld` is high for exactly the one cycle after a strobe that raises an interrupt. A `req_stb` on its own in a legal quadrant with a valid access type raises nothing and leaves every registered output unchanged.
- R10: After reset `irq_vld`, `irq_kind`, `irq_err`, `fault_syn` and `fault_dar` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ea | input | EA_W | Effective address of the access |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| hv_mode | input | 1 | Hypervisor mode when high, guest mode when low |
| lpid_reg | input | LPID_W | Partition identifier register value |
| pid_reg | input | PID_W | Process identifier register value |
| req_stb | input | 1 | A translation request is presented this cycle |
| sfault_stb | input | 1 | The walker reports a storage fault this cycle |
| fault_cause | input | CAUSE_W | Cause word that comes with `sfault_stb` |
| ctx_ok | output | 1 | The quadrant is legal in the current mode |
| ctx_lpid | output | LPID_W | Partition identifier selected for the walk |
| ctx_pid | output | PID_W | Process identifier selected for the walk |
| irq_vld | output | 1 | One-cycle interrupt pulse |
| irq_kind | output | 2 | 0 data segment, 1 instruction segment, 2 data storage, 3 instruction storage |
| irq_err | output | CAUSE_W | Error code register |
| fault_syn | output | CAUSE_W | Syndrome register |
| fault_dar | output | EA_W | Fault address register |

## Verification
Properties checked on every cycle:
- Hypervisor mode always qualifies a context, and guest quadrants 1 and 2 never do.
- The interrupt pulse never appears without a strobe on the cycle before.
- Segment interrupts clear the error code.
- Instruction interrupts leave the fault address alone, and instruction storage interrupts also leave the syndrome alone.
- Data storage interrupts capture the previous cycle's address.

The remaining behaviour can only be shown by the bench's scenarios. This covers the exact identifier values for each of the eight mode and quadrant combinations, the store bit in the syndrome, the configuration-error syndrome, the priority order when causes coincide, and the fact that registers hold across a request that raises nothing.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        IRQ_DSEG  = 2'd0,
        IRQ_ISEG  = 2'd1,
        IRQ_DSTOR = 2'd2,
        IRQ_ISTOR = 2'd3
    } irq_kind_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_BAD = 2'd3
    } acc_e;

endpackage

// File: rtl/xlat_ctx_sel.sv
module xlat_ctx_sel #(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic              hv_mode,
    input  logic [1:0]        quad,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    output logic              ok,
    output logic [LPID_W-1:0] lpid,
    output logic [PID_W-1:0]  pid
);
    logic use_lpid;
    logic use_pid;

    always_comb begin
        ok       = 1'b1;
        use_lpid = 1'b0;
        use_pid  = 1'b0;
        if (hv_mode) begin
            unique case (quad)
                2'd0: use_pid = 1'b1;
                2'd1: begin use_lpid = 1'b1; use_pid = 1'b1; end
                2'd2: use_lpid = 1'b1;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin use_lpid = 1'b1; use_pid = 1'b1; end
                2'd3: use_lpid = 1'b1;
                default: ok = 1'b0;
            endcase
        end
        lpid = use_lpid ? lpid_reg : '0;
        pid  = use_pid  ? pid_reg  : '0;
    end
endmodule

// File: rtl/xlat_fault_gen.sv
module xlat_fault_gen
    import xlat_pkg::*;
#(
    parameter int EA_W      = 64,
    parameter int CAUSE_W   = 32,
    parameter int STORE_BIT = 25,
    parameter int CFG_BIT   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EA_W-1:0]    ea,
    input  logic [1:0]         acc_type,
    input  logic               ctx_ok,
    input  logic               req_stb,
    input  logic               sfault_stb,
    input  logic [CAUSE_W-1:0] fault_cause,
    output logic               irq_vld,
    output logic [1:0]         irq_kind,
    output logic [CAUSE_W-1:0] irq_err,
    output logic [CAUSE_W-1:0] fault_syn,
    output logic [EA_W-1:0]    fault_dar
);
    localparam logic [CAUSE_W-1:0] STORE_MASK = CAUSE_W'(1) << STORE_BIT;
    localparam logic [CAUSE_W-1:0] CFG_MASK   = CAUSE_W'(1) << CFG_BIT;

    typedef struct packed {
        logic               vld;
        irq_kind_e          kind;
        logic [CAUSE_W-1:0] err;
        logic [CAUSE_W-1:0] syn;
        logic [EA_W-1:0]    dar;
    } rep_t;

    rep_t rep_d, rep_q;
    acc_e acc;
    logic is_exec;

    assign acc     = acc_e'(acc_type);
    assign is_exec = (acc == ACC_EX);

    always_comb begin
        rep_d     = rep_q;
        rep_d.vld = 1'b0;
        if (req_stb || sfault_stb) begin
            if (!ctx_ok) begin
                rep_d.vld = 1'b1;
                rep_d.err = '0;
                if (is_exec) begin
                    rep_d.kind = IRQ_ISEG;
                end else begin
                    rep_d.kind = IRQ_DSEG;
                    rep_d.dar  = ea;
                end
            end else if (acc == ACC_BAD) begin
                rep_d.vld  = 1'b1;
                rep_d.kind = IRQ_DSTOR;
                rep_d.syn  = CFG_MASK;
                rep_d.dar  = ea;
                rep_d.err  = '0;
            end else if (sfault_stb) begin
                rep_d.vld = 1'b1;
                if (is_exec) begin
                    rep_d.kind = IRQ_ISTOR;
                    rep_d.err  = fault_cause;
                end else begin
                    rep_d.kind = IRQ_DSTOR;
                    rep_d.syn  = fault_cause | ((acc == ACC_WR) ? STORE_MASK : '0);
                    rep_d.dar  = ea;
                    rep_d.err  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign irq_vld   = rep_q.vld;
    assign irq_kind  = rep_q.kind;
    assign irq_err   = rep_q.err;
    assign fault_syn = rep_q.syn;
    assign fault_dar = rep_q.dar;
endmodule

// File: rtl/xlat_ctx_fault.sv
module xlat_ctx_fault #(
    parameter int EA_W      = 64,
    parameter int LPID_W    = 12,
    parameter int PID_W     = 20,
    parameter int CAUSE_W   = 32,
    parameter int STORE_BIT = 25,
    parameter int CFG_BIT   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EA_W-1:0]    ea,
    input  logic [1:0]         acc_type,
    input  logic               hv_mode,
    input  logic [LPID_W-1:0]  lpid_reg,
    input  logic [PID_W-1:0]   pid_reg,
    input  logic               req_stb,
    input  logic               sfault_stb,
    input  logic [CAUSE_W-1:0] fault_cause,
    output logic               ctx_ok,
    output logic [LPID_W-1:0]  ctx_lpid,
    output logic [PID_W-1:0]   ctx_pid,
    output logic               irq_vld,
    output logic [1:0]         irq_kind,
    output logic [CAUSE_W-1:0] irq_err,
    output logic [CAUSE_W-1:0] fault_syn,
    output logic [EA_W-1:0]    fault_dar
);
    localparam int QUAD_LSB = EA_W - 2;

    logic [1:0] quad;
    assign quad = ea[EA_W-1:QUAD_LSB];

    xlat_ctx_sel #(.LPID_W(LPID_W), .PID_W(PID_W)) u_sel (
        .hv_mode (hv_mode),
        .quad    (quad),
        .lpid_reg(lpid_reg),
        .pid_reg (pid_reg),
        .ok      (ctx_ok),
        .lpid    (ctx_lpid),
        .pid     (ctx_pid)
    );

    xlat_fault_gen #(
        .EA_W(EA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT), .CFG_BIT(CFG_BIT)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ea         (ea),
        .acc_type   (acc_type),
        .ctx_ok     (ctx_ok),
        .req_stb    (req_stb),
        .sfault_stb (sfault_stb),
        .fault_cause(fault_cause),
        .irq_vld    (irq_vld),
        .irq_kind   (irq_kind),
        .irq_err    (irq_err),
        .fault_syn  (fault_syn),
        .fault_dar  (fault_dar)
    );
endmodule

// File: rtl/xlat_ctx_fault_chk.sv
module xlat_ctx_fault_chk #(
    parameter int EA_W    = 64,
    parameter int CAUSE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [EA_W-1:0]    ea,
    input logic               hv_mode,
    input logic               req_stb,
    input logic               sfault_stb,
    input logic               ctx_ok,
    input logic               irq_vld,
    input logic [1:0]         irq_kind,
    input logic [CAUSE_W-1:0] irq_err,
    input logic [CAUSE_W-1:0] fault_syn,
    input logic [EA_W-1:0]    fault_dar
);
    logic [1:0] quad;
    assign quad = ea[EA_W-1:EA_W-2];

    p_hv_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hv_mode |-> ctx_ok);

    p_guest_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hv_mode && (quad == 2'd1 || quad == 2'd2)) |-> !ctx_ok);

    p_no_stray_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_stb || sfault_stb) |=> !irq_vld);

    p_seg_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vld && (irq_kind == 2'd0 || irq_kind == 2'd1)) |-> (irq_err == '0));

    p_iseg_keeps_dar_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vld && irq_kind == 2'd1) |-> $stable(fault_dar));

    p_istor_keeps_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vld && irq_kind == 2'd3) |-> ($stable(fault_dar) && $stable(fault_syn)));

    p_dstor_dar_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vld && irq_kind == 2'd2) |-> (fault_dar == $past(ea)));
endmodule

bind xlat_ctx_fault xlat_ctx_fault_chk #(.EA_W(EA_W), .CAUSE_W(CAUSE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ea        (ea),
    .hv_mode   (hv_mode),
    .req_stb   (req_stb),
    .sfault_stb(sfault_stb),
    .ctx_ok    (ctx_ok),
    .irq_vld   (irq_vld),
    .irq_kind  (irq_kind),
    .irq_err   (irq_err),
    .fault_syn (fault_syn),
    .fault_dar (fault_dar)
);

// File: tb/xlat_ctx_fault_bench.sv
module xlat_ctx_fault_bench;
    localparam int EA_W = 64;
    localparam int LW   = 12;
    localparam int PW   = 20;
    localparam int CW   = 32;
    localparam logic [LW-1:0] LPID_V = 12'hA5C;
    localparam logic [PW-1:0] PID_V  = 20'h31F2E;
    localparam logic [CW-1:0] STORE_M = 32'h0200_0000;
    localparam logic [CW-1:0] CFG_M   = 32'h0000_0200;

    // {hv, quad[1:0], ok, use_lpid, use_pid}
    localparam logic [5:0] MAP_TBL [8] = '{
        6'b1_00_101, 6'b1_01_111, 6'b1_10_110, 6'b1_11_100,
        6'b0_00_111, 6'b0_01_000, 6'b0_10_000, 6'b0_11_110
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [EA_W-1:0] ea = '0;
    logic [1:0] acc_type = 2'd0;
    logic hv_mode = 1'b0;
    logic req_stb = 1'b0;
    logic sfault_stb = 1'b0;
    logic [CW-1:0] fault_cause = '0;
    logic ctx_ok;
    logic [LW-1:0] ctx_lpid;
    logic [PW-1:0] ctx_pid;
    logic irq_vld;
    logic [1:0] irq_kind;
    logic [CW-1:0] irq_err, fault_syn;
    logic [EA_W-1:0] fault_dar;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [CW-1:0] e_err = '0, e_syn = '0;
    logic [EA_W-1:0] e_dar = '0;

    always #2 clk = ~clk;

    xlat_ctx_fault u_xlat_ctx_fault (
        .clk(clk), .rst_n(rst_n), .ea(ea), .acc_type(acc_type), .hv_mode(hv_mode),
        .lpid_reg(LPID_V), .pid_reg(PID_V), .req_stb(req_stb), .sfault_stb(sfault_stb),
        .fault_cause(fault_cause), .ctx_ok(ctx_ok), .ctx_lpid(ctx_lpid), .ctx_pid(ctx_pid),
        .irq_vld(irq_vld), .irq_kind(irq_kind), .irq_err(irq_err), .fault_syn(fault_syn),
        .fault_dar(fault_dar)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Present one strobe cycle, then check registered results on the following negedge.
    task automatic fire(input string tag, input logic rq, input logic sf, input logic hv,
                        input logic [1:0] q, input logic [1:0] acc, input logic [CW-1:0] cause,
                        input logic exp_vld, input logic [1:0] exp_kind);
        @(negedge clk);
        hv_mode = hv; ea = {q, 30'h0, 32'h1357_9BD0 ^ {30'h0, q}}; acc_type = acc;
        fault_cause = cause; req_stb = rq; sfault_stb = sf;
        @(negedge clk);
        req_stb = 1'b0; sfault_stb = 1'b0;
        check({tag, " vld"}, 64'(irq_vld), 64'(exp_vld));
        if (exp_vld) check({tag, " kind"}, 64'(irq_kind), 64'(exp_kind));
        check({tag, " err"}, 64'(irq_err), 64'(e_err));
        check({tag, " syn"}, 64'(fault_syn), 64'(e_syn));
        check({tag, " dar"}, fault_dar, e_dar);
        @(negedge clk);
        check({tag, " pulse end R9"}, 64'(irq_vld), 64'd0);
    endtask

    function automatic logic [EA_W-1:0] ea_of(input logic [1:0] q);
        return {q, 30'h0, 32'h1357_9BD0 ^ {30'h0, q}};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 vld", 64'(irq_vld), 0);
        check("R10 kind", 64'(irq_kind), 0);
        check("R10 err", 64'(irq_err), 0);
        check("R10 syn", 64'(fault_syn), 0);
        check("R10 dar", fault_dar, 0);
        rst_n = 1'b1;

        // R1 R2 R3 mapping table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            hv_mode = MAP_TBL[i][5];
            ea = ea_of(MAP_TBL[i][4:3]);
            #1;
            check($sformatf("R1/R2/R3 ok row%0d", i), 64'(ctx_ok), 64'(MAP_TBL[i][2]));
            check($sformatf("R1/R2/R3 lpid row%0d", i), 64'(ctx_lpid),
                  MAP_TBL[i][1] ? 64'(LPID_V) : 64'd0);
            check($sformatf("R1/R2/R3 pid row%0d", i), 64'(ctx_pid),
                  MAP_TBL[i][0] ? 64'(PID_V) : 64'd0);
        end

        // R4 data segment: guest quadrant 1 read
        e_err = '0; e_dar = ea_of(2'd1);
        fire("R4 dseg", 1, 0, 0, 2'd1, 2'd0, 32'h0, 1, 2'd0);
        // R4 instruction segment: guest quadrant 2 execute, dar held
        fire("R4 iseg", 1, 0, 0, 2'd2, 2'd2, 32'h0, 1, 2'd1);
        // R5 instruction storage
        e_err = 32'h4000_0000;
        fire("R5 istor", 0, 1, 1, 2'd0, 2'd2, 32'h4000_0000, 1, 2'd3);
        // R6 data storage write with store bit
        e_err = '0; e_syn = 32'h0800_0000 | STORE_M; e_dar = ea_of(2'd3);
        fire("R6 dstor wr", 0, 1, 1, 2'd3, 2'd1, 32'h0800_0000, 1, 2'd2);
        // R6 data storage read, guest quadrant 0
        e_syn = 32'h4000_0000; e_dar = ea_of(2'd0);
        fire("R6 dstor rd", 0, 1, 0, 2'd0, 2'd0, 32'h4000_0000, 1, 2'd2);
        // R7 reserved access type
        e_syn = CFG_M; e_dar = ea_of(2'd1);
        fire("R7 cfg", 1, 0, 1, 2'd1, 2'd3, 32'h0, 1, 2'd2);
        // R8 segment beats config and storage
        e_dar = ea_of(2'd2);
        fire("R8 seg first", 1, 1, 0, 2'd2, 2'd3, 32'h0000_0001, 1, 2'd0);
        // R8 config beats storage fault
        e_dar = ea_of(2'd2);
        fire("R8 cfg over storage", 0, 1, 1, 2'd2, 2'd3, 32'h0000_0040, 1, 2'd2);
        // R9 legal plain request raises nothing, registers hold
        fire("R9 quiet req", 1, 0, 1, 2'd0, 2'd1, 32'hFFFF_FFFF, 0, 2'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule